// File: doc/BRIEF.md
# Mini UART register and FIFO frontend

This block is the register-facing side of a simple UART. It sits behind a 32-bit memory-mapped register bus. Bytes coming from the line side arrive on a valid/ready byte stream and are held in an eight-entry receive FIFO until software reads them. A byte that software writes to the data register leaves on the same cycle as a one-cycle strobe on an output byte stream. The transmit path therefore never holds anything, and it always reports empty and idle.

Software sees an interrupt-enable register, an interrupt-identification register, a line-status word, a fixed control word and an extended-status word that carries the receive fill level. One level interrupt output combines the two interrupt sources. The registers for line control, modem control, modem status, scratch and baud divisor are present only as address holes: they read zero and ignore writes. Register reads are combinational in the access cycle. Every state change takes effect at the clock edge that ends the access.

Top module: `mu_frontend`

## Requirements
- R1: After reset the FIFO is empty, both enable bits are clear, `irq` is low, `rx_ready` is high, the enable register reads 0xC0, the line status reads 0x60 and the extended status reads 0x30E.
- R2: A byte is taken from the input stream in a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is high only while fewer than 8 bytes are held, so a byte offered to a full FIFO is not accepted and the fill level never exceeds 8.
- R3: A read of the data register (offset 0x00) returns the oldest held byte in bits 7:0 and removes it. A read of an empty FIFO removes nothing, and the fill level stays 0.
- R4: A write to the data register raises `tx_valid` in the same cycle, with `tx_byte` equal to write-data bits 7:0.
- R5: The interrupt-enable register (offset 0x04) keeps only write-data bit 0 (receive) and bit 1 (transmit). It reads back as 0xC0 ORed with those two bits.
- R6: `irq` is high when the receive enable is set and the FIFO holds data, or whenever the transmit enable is set. Otherwise it is low.
- R7: The identification register (offset 0x08) reads 0xC0 + (0x4 if the FIFO holds data, else 0x2) + (0x1 if `irq` is low). Receive is the source reported when both sources are active.
- R8: A write to the identification register with write-data bit 1 set empties the FIFO. A write with bit 1 clear leaves the FIFO unchanged.
- R9: The line status (offset 0x14) reads 0x60 with bit 0 set while data is held. The control word (offset 0x20) always reads 0x3 and ignores writes.
- R10: The extended status (offset 0x24) reads 0x30E, with bit 0 set while data is held and the fill level in bits 19:16.
- R11: Offsets 0x0C, 0x10, 0x18, 0x1C and 0x28, and any offset above 0x28, read as zero. Writes to them change no state.
- R12: A data-register read and an accepted input byte in the same cycle leave the fill level unchanged and keep first-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset inside the UART window (bits 5:2 select the register) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | FIFO can take a byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request, level |

## Verification
Read data and the transmit strobe are due in the access cycle itself. A pop, a flush, an enable update or an accepted input byte shows up in the status words and on `irq` in the cycle after the clock edge that ends the access. After `rst_n` rises, the block needs two edges before it responds to the bus. The bench changes inputs on the falling edge and samples outputs 1 ns before the next rising edge, so same-cycle results are read before the edge and state changes are read one full cycle after the edge that caused them.

// File: rtl/mu_pkg.sv
package mu_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [IDX_W-1:0] {
    RG_DATA  = 4'd0,
    RG_IEN   = 4'd1,
    RG_IID   = 4'd2,
    RG_LCTL  = 4'd3,
    RG_MCTL  = 4'd4,
    RG_LSTAT = 4'd5,
    RG_MSTAT = 4'd6,
    RG_SCR   = 4'd7,
    RG_CTRL  = 4'd8,
    RG_XSTAT = 4'd9,
    RG_BAUD  = 4'd10
  } reg_idx_e;

  localparam logic [BUS_W-1:0] IEN_FIXED   = 32'h0000_00C0;
  localparam logic [BUS_W-1:0] IID_FIXED   = 32'h0000_00C0;
  localparam logic [BUS_W-1:0] LSTAT_FIXED = 32'h0000_0060;
  localparam logic [BUS_W-1:0] CTRL_FIXED  = 32'h0000_0003;
  localparam logic [BUS_W-1:0] XSTAT_FIXED = 32'h0000_030E;
  localparam int unsigned      XSTAT_LVL_LSB = 16;
endpackage

// File: rtl/mu_rst_sync.sv
module mu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shf_q <= '0;
    else        shf_q <= {shf_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shf_q[STAGES-1];
endmodule

// File: rtl/mu_rx_fifo.sv
module mu_rx_fifo #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  input  logic              flush,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  level,
  output logic              full
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PTR_W-1:0]  wr_idx;
  logic [31:0]       wr_sum;
  logic              pop_eff;
  logic              state_en;

  assign pop_eff = pop_req && (cnt_q != '0);

  always_comb begin
    wr_sum = 32'(rd_ptr_q) + 32'(cnt_q);
    if (wr_sum >= DEPTH) wr_sum = wr_sum - DEPTH;
    wr_idx = wr_sum[PTR_W-1:0];
  end

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (pop_eff) begin
      rd_ptr_d = (32'(rd_ptr_q) == DEPTH - 1) ? '0 : rd_ptr_q + 1'b1;
    end
    if (flush) begin
      cnt_d = '0;
    end else if (push && !pop_eff) begin
      cnt_d = cnt_q + 1'b1;
    end else if (pop_eff && !push) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  assign state_en = push || pop_eff || flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (state_en) begin
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_idx] <= push_data;
  end

  assign head  = mem_q[rd_ptr_q];
  assign level = cnt_q;
  assign full  = (32'(cnt_q) == DEPTH);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= DEPTH); // R2
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop_req && !flush) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && cnt_q == '0 && !push && !flush) |=> (cnt_q == '0)); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0)); // R8
  AST_SIMUL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop_req && cnt_q != '0 && !flush) |=> $stable(cnt_q)); // R12
endmodule

// File: rtl/mu_rd_mux.sv
module mu_rd_mux
  import mu_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [1:0]        ien,
  input  logic [CNT_W-1:0]  level,
  input  logic [BYTE_W-1:0] head,
  output logic [BUS_W-1:0]  rdata,
  output logic              irq
);
  logic has_data;
  logic [BUS_W-1:0] iid_word;

  assign has_data = (level != '0);
  assign irq      = (ien[0] && has_data) || ien[1];

  always_comb begin
    iid_word = IID_FIXED;
    iid_word = iid_word | (has_data ? 32'h4 : 32'h2);
    if (!irq) iid_word = iid_word | 32'h1;
  end

  always_comb begin
    rdata = '0;
    case (idx)
      RG_DATA:  rdata = 32'(head);
      RG_IEN:   rdata = IEN_FIXED | 32'(ien);
      RG_IID:   rdata = iid_word;
      RG_LSTAT: rdata = LSTAT_FIXED | 32'(has_data);
      RG_CTRL:  rdata = CTRL_FIXED;
      RG_XSTAT: rdata = XSTAT_FIXED | 32'(has_data) | (32'(level) << XSTAT_LVL_LSB);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/mu_frontend.sv
module mu_frontend
  import mu_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  logic              rst_n_s;
  logic [IDX_W-1:0]  idx;
  logic              rd_acc, wr_acc;
  logic              pop_req, flush, push;
  logic              fifo_full;
  logic [CNT_W-1:0]  level;
  logic [BYTE_W-1:0] head;
  logic [1:0]        ien_q, ien_d;
  logic              ien_en;

  mu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  assign idx    = bus_addr[ADDR_W-1:2];
  assign rd_acc = rst_n_s && bus_sel && !bus_we;
  assign wr_acc = rst_n_s && bus_sel && bus_we;

  assign pop_req  = rd_acc && (idx == RG_DATA);
  assign flush    = wr_acc && (idx == RG_IID) && bus_wdata[1];
  assign rx_ready = rst_n_s && !fifo_full;
  assign push     = rx_valid && rx_ready;

  assign tx_valid = wr_acc && (idx == RG_DATA);
  assign tx_byte  = bus_wdata[BYTE_W-1:0];

  assign ien_en = wr_acc && (idx == RG_IEN);
  always_comb begin
    ien_d = ien_q;
    if (ien_en) ien_d = bus_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    ien_q <= '0;
    else if (ien_en) ien_q <= ien_d;
  end

  mu_rx_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n_s), .push(push), .push_data(rx_byte),
    .pop_req(pop_req), .flush(flush), .head(head), .level(level),
    .full(fifo_full)
  );

  mu_rd_mux #(.CNT_W(CNT_W)) u_rd (
    .idx(idx), .ien(ien_q), .level(level), .head(head),
    .rdata(bus_rdata), .irq(irq)
  );

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (32'(level) == FIFO_DEPTH) |-> !rx_ready); // R2
  AST_IRQ_TX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n_s)
    ien_q[1] |-> irq); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ien_q == 2'b00) |-> !irq); // R6
  AST_IEN_READBACK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_acc && idx == RG_IEN) |-> (bus_rdata[7:0] == {6'b110000, ien_q})); // R5
  AST_IEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    ien_en |=> (ien_q == $past(bus_wdata[1:0]))); // R5
  AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n_s)
    tx_valid |-> (bus_sel && bus_we)); // R4
endmodule

// File: tb/mu_frontend_test.sv
`timescale 1ns/1ps
module mu_frontend_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        rx_ready, tx_valid;
  logic [7:0]  tx_byte;
  logic        irq;
  int checks = 0;
  int fails  = 0;
  logic        seen_tx;
  logic [7:0]  seen_tx_byte;

  always #2.5 clk = ~clk;

  mu_frontend uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  // All tasks start and end at a falling edge.
  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1.5; d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] v);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    #1.5; seen_tx = tx_valid; seen_tx_byte = tx_byte;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b, output logic took);
    rx_valid = 1'b1; rx_byte = b;
    #1.5; took = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic expect_read(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    chk_eq(tag, d, exp);
  endtask

  task automatic t_reset;
    #1.5;
    chk_eq("R1 irq", {31'd0, irq}, 32'd0);
    chk_eq("R1 rx_ready", {31'd0, rx_ready}, 32'd1);
    @(negedge clk);
    expect_read("R1 ien", 6'h04, 32'hC0);
    expect_read("R1 lstat", 6'h14, 32'h60);
    expect_read("R1 xstat", 6'h24, 32'h30E);
  endtask

  task automatic t_tx;
    #1.5; chk_eq("R4 idle", {31'd0, tx_valid}, 32'd0);
    @(negedge clk);
    bus_write(6'h00, 32'h0000_01A5);
    chk_eq("R4 strobe", {31'd0, seen_tx}, 32'd1);
    chk_eq("R4 byte", {24'd0, seen_tx_byte}, 32'hA5);
    expect_read("R4 fifo untouched", 6'h24, 32'h30E);
  endtask

  task automatic t_ien;
    bus_write(6'h04, 32'hFFFF_FFFC);
    expect_read("R5 upper dropped", 6'h04, 32'hC0);
    bus_write(6'h04, 32'h0000_0003);
    expect_read("R5 both", 6'h04, 32'hC3);
    bus_write(6'h04, 32'h0);
    expect_read("R5 clear", 6'h04, 32'hC0);
  endtask

  task automatic t_fill;
    logic took;
    for (int i = 0; i < 8; i++) begin
      push_byte(8'h10 + 8'(i), took);
      chk_eq("R2 accepted", {31'd0, took}, 32'd1);
    end
    push_byte(8'h99, took);
    chk_eq("R2 full refuses", {31'd0, took}, 32'd0);
    expect_read("R10 full level", 6'h24, 32'h0008_030F);
    expect_read("R9 lstat data", 6'h14, 32'h61);
    for (int i = 0; i < 8; i++) begin
      expect_read("R3 order", 6'h00, 32'h10 + 32'(i));
    end
    expect_read("R10 drained", 6'h24, 32'h30E);
    begin
      logic [31:0] d;
      bus_read(6'h00, d);
    end
    expect_read("R3 empty read no underflow", 6'h24, 32'h30E);
    expect_read("R9 lstat empty", 6'h14, 32'h60);
  endtask

  task automatic t_irq;
    logic took;
    bus_write(6'h04, 32'h1);
    #1.5; chk_eq("R6 rx en empty", {31'd0, irq}, 32'd0); @(negedge clk);
    expect_read("R7 none pending", 6'h08, 32'hC3);
    push_byte(8'h5A, took);
    #1.5; chk_eq("R6 rx data", {31'd0, irq}, 32'd1); @(negedge clk);
    expect_read("R7 rx pending", 6'h08, 32'hC4);
    bus_write(6'h08, 32'h4);
    expect_read("R8 bit1 clear keeps", 6'h24, 32'h0001_030F);
    bus_write(6'h04, 32'h3);
    expect_read("R7 rx priority", 6'h08, 32'hC4);
    bus_write(6'h08, 32'h2);
    expect_read("R8 flushed", 6'h24, 32'h30E);
    #1.5; chk_eq("R6 tx level", {31'd0, irq}, 32'd1); @(negedge clk);
    expect_read("R7 tx pending", 6'h08, 32'hC2);
    bus_write(6'h04, 32'h0);
    #1.5; chk_eq("R6 off", {31'd0, irq}, 32'd0); @(negedge clk);
  endtask

  task automatic t_unimpl;
    logic took;
    push_byte(8'h33, took);
    bus_write(6'h04, 32'h1);
    foreach (uut.u_rd.rdata[i]) ; // no-op
    bus_write(6'h0C, 32'hFFFF_FFFF);
    bus_write(6'h10, 32'hFFFF_FFFF);
    bus_write(6'h1C, 32'hFFFF_FFFF);
    bus_write(6'h20, 32'h0);
    bus_write(6'h28, 32'hFFFF_FFFF);
    bus_write(6'h3C, 32'hFFFF_FFFF);
    expect_read("R11 lctl", 6'h0C, 32'h0);
    expect_read("R11 mctl", 6'h10, 32'h0);
    expect_read("R11 mstat", 6'h18, 32'h0);
    expect_read("R11 scratch", 6'h1C, 32'h0);
    expect_read("R11 baud", 6'h28, 32'h0);
    expect_read("R11 hole", 6'h30, 32'h0);
    expect_read("R9 ctrl", 6'h20, 32'h3);
    expect_read("R11 ien kept", 6'h04, 32'hC1);
    expect_read("R11 fifo kept", 6'h24, 32'h0001_030F);
    expect_read("R11 byte kept", 6'h00, 32'h33);
    bus_write(6'h04, 32'h0);
  endtask

  task automatic t_simul;
    logic took;
    logic [31:0] d;
    push_byte(8'hA1, took);
    push_byte(8'hB2, took);
    rx_valid = 1'b1; rx_byte = 8'hC3;
    bus_read(6'h00, d);
    rx_valid = 1'b0;
    chk_eq("R12 head", d, 32'hA1);
    expect_read("R12 level kept", 6'h24, 32'h0002_030F);
    expect_read("R12 next", 6'h00, 32'hB2);
    expect_read("R12 last", 6'h00, 32'hC3);
    expect_read("R12 empty", 6'h24, 32'h30E);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; rx_valid = 1'b0; rx_byte = '0;
    seen_tx = 1'b0; seen_tx_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_tx;
    t_ien;
    t_fill;
    t_irq;
    t_unimpl;
    t_simul;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule